// File: doc/BRIEF.md
# Reservation Station with Result Broadcast

This block holds operations waiting for one functional unit class in an out-of-order core. An operation enters through the issue port with one destination and two source register numbers. At that moment each source is looked up in a register status table. A source with no pending producer takes its value from the local register file. A source with a pending producer takes the tag of the entry that will produce it. The destination register is then marked as owned by the new entry.

Waiting entries watch the result broadcast bus and pick up a value as soon as its tag appears. An entry whose two operands are present is offered on the dispatch port, and the oldest such entry goes first. The functional unit later returns the result on the broadcast bus with the entry's tag. That broadcast frees the entry. It also updates a register only when the register's status still names that tag, so renaming removes write-after-read and write-after-write hazards.

Top module: `resv_station`

## Requirements
- R1: An accepted issue takes the lowest-numbered free entry, and `iss_tag` reports that entry's index plus one before the edge. Tags 1 to NENT name entries, and tag value 0 means the operand is present.
- R2: A waiting operand whose tag equals `cdb_tag` while `cdb_valid` is high captures `cdb_data` at that edge. The entry can be offered for dispatch in the next cycle.
- R3: At issue, a source whose register status is 0 reads the register file value. A source with a nonzero status records that tag and waits.
- R4: With no free entry, `iss_ready` is low and an issue attempt is ignored: no entry is filled and no register status changes.
- R5: An entry is offered on `dsp_valid` only when both operands are present. It stays offered until `dsp_ready` accepts it, and after that it is never offered again.
- R6: A broadcast writes a register and clears its status only when the register's status equals `cdb_tag`. Otherwise the register keeps its value.
- R7: When several entries are ready, the one issued earliest is offered first, whatever its index.
- R8: A broadcast in the same cycle as an issue whose source names that tag is forwarded into the new entry, which is then ready in the next cycle.
- R9: A broadcast frees the entry whose tag it carries, and that entry can be allocated again from the next cycle on.
- R10: After reset all entries are free, `dsp_valid` is low, every register reads 0 and no register has a pending producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OPW | Operation code carried to dispatch |
| iss_dst | input | log2(NREG) | Destination register |
| iss_src_a | input | log2(NREG) | First source register |
| iss_src_b | input | log2(NREG) | Second source register |
| iss_ready | output | 1 | A free entry exists |
| iss_tag | output | log2(NENT+1) | Tag the issue would receive |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | log2(NENT+1) | Tag of the producing entry |
| cdb_data | input | DW | Broadcast result value |
| dsp_valid | output | 1 | A ready entry is offered |
| dsp_ready | input | 1 | Functional unit accepts the offer |
| dsp_op | output | OPW | Offered operation code |
| dsp_tag | output | log2(NENT+1) | Tag of the offered entry |
| dsp_opa | output | DW | First operand value |
| dsp_opb | output | DW | Second operand value |

## Verification
A stale tag or a missed capture leaves an entry waiting forever. That shows at the dispatch port as `dsp_valid` staying low, one cycle after the broadcast that should have woken the entry. A corrupted register value or status shows on the operands of the next operation that reads the register, as soon as it is offered. A wrong age order shows as the wrong `dsp_tag` among several ready entries. A failed free shows as `iss_ready` or `iss_tag` being wrong on the following issue.

// File: rtl/resv_station.sv
`timescale 1ns/1ps
module resv_station #(
  parameter int NENT = 4,
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int OPW  = 4,
  localparam int TW  = $clog2(NENT + 1),
  localparam int RW  = $clog2(NREG),
  localparam int IW  = $clog2(NENT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  input  logic [OPW-1:0] iss_op,
  input  logic [RW-1:0]  iss_dst,
  input  logic [RW-1:0]  iss_src_a,
  input  logic [RW-1:0]  iss_src_b,
  output logic           iss_ready,
  output logic [TW-1:0]  iss_tag,
  input  logic           cdb_valid,
  input  logic [TW-1:0]  cdb_tag,
  input  logic [DW-1:0]  cdb_data,
  output logic           dsp_valid,
  input  logic           dsp_ready,
  output logic [OPW-1:0] dsp_op,
  output logic [TW-1:0]  dsp_tag,
  output logic [DW-1:0]  dsp_opa,
  output logic [DW-1:0]  dsp_opb
);

  logic [NENT-1:0] busy, sent, rdy, pick;
  logic [OPW-1:0]  e_op [NENT];
  logic [DW-1:0]   e_va [NENT];
  logic [DW-1:0]   e_vb [NENT];
  logic [TW-1:0]   e_qa [NENT];
  logic [TW-1:0]   e_qb [NENT];
  logic [NENT-1:0] older [NENT];
  logic [DW-1:0]   regf [NREG];
  logic [TW-1:0]   rstat [NREG];

  logic [IW-1:0] alloc_idx;
  logic          do_iss;
  logic [DW-1:0] new_va, new_vb;
  logic [TW-1:0] new_qa, new_qb;
  logic [TW-1:0] st_a, st_b;

  always_comb begin
    alloc_idx = '0;
    iss_ready = 1'b0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        alloc_idx = IW'(i);
        iss_ready = 1'b1;
      end
    end
  end

  assign iss_tag = TW'(alloc_idx) + TW'(1);
  assign do_iss  = iss_valid && iss_ready;
  assign st_a    = rstat[iss_src_a];
  assign st_b    = rstat[iss_src_b];

  always_comb begin
    new_va = regf[iss_src_a];
    new_qa = '0;
    if (st_a != '0) begin
      if (cdb_valid && cdb_tag == st_a) new_va = cdb_data;
      else begin
        new_va = '0;
        new_qa = st_a;
      end
    end
    new_vb = regf[iss_src_b];
    new_qb = '0;
    if (st_b != '0) begin
      if (cdb_valid && cdb_tag == st_b) new_vb = cdb_data;
      else begin
        new_vb = '0;
        new_qb = st_b;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NENT; i++)
      rdy[i] = busy[i] && !sent[i] && e_qa[i] == '0 && e_qb[i] == '0;
  end

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      pick[i] = rdy[i];
      for (int j = 0; j < NENT; j++)
        if (rdy[j] && older[j][i]) pick[i] = 1'b0;
    end
  end

  always_comb begin
    dsp_op  = '0;
    dsp_tag = '0;
    dsp_opa = '0;
    dsp_opb = '0;
    for (int i = 0; i < NENT; i++) begin
      if (pick[i]) begin
        dsp_op  = e_op[i];
        dsp_tag = TW'(i + 1);
        dsp_opa = e_va[i];
        dsp_opb = e_vb[i];
      end
    end
  end

  assign dsp_valid = |rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      sent <= '0;
      for (int i = 0; i < NENT; i++) begin
        e_op[i]  <= '0;
        e_va[i]  <= '0;
        e_vb[i]  <= '0;
        e_qa[i]  <= '0;
        e_qb[i]  <= '0;
        older[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) begin
        regf[r]  <= '0;
        rstat[r] <= '0;
      end
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (cdb_valid && busy[i] && e_qa[i] != '0 && e_qa[i] == cdb_tag) begin
          e_va[i] <= cdb_data;
          e_qa[i] <= '0;
        end
        if (cdb_valid && busy[i] && e_qb[i] != '0 && e_qb[i] == cdb_tag) begin
          e_vb[i] <= cdb_data;
          e_qb[i] <= '0;
        end
        if (dsp_ready && pick[i]) sent[i] <= 1'b1;
        if (cdb_valid && cdb_tag == TW'(i + 1)) begin
          busy[i] <= 1'b0;
          sent[i] <= 1'b0;
        end
      end
      if (do_iss) begin
        busy[alloc_idx]  <= 1'b1;
        sent[alloc_idx]  <= 1'b0;
        e_op[alloc_idx]  <= iss_op;
        e_va[alloc_idx]  <= new_va;
        e_vb[alloc_idx]  <= new_vb;
        e_qa[alloc_idx]  <= new_qa;
        e_qb[alloc_idx]  <= new_qb;
        older[alloc_idx] <= '0;
        for (int j = 0; j < NENT; j++)
          older[j][alloc_idx] <= busy[j];
      end
      for (int r = 0; r < NREG; r++) begin
        if (cdb_valid && rstat[r] != '0 && rstat[r] == cdb_tag) begin
          regf[r]  <= cdb_data;
          rstat[r] <= '0;
        end
      end
      if (do_iss) rstat[iss_dst] <= iss_tag;
    end
  end

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready && !cdb_valid |=> $stable(busy));

  p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && dsp_ready |=> !(dsp_valid && dsp_tag == $past(dsp_tag)));

  p_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));

  for (genvar g = 0; g < NENT; g++) begin : g_ent_chk
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid && busy[g] && cdb_tag != '0 && e_qa[g] == cdb_tag |=> e_qa[g] == '0);
    p_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid && busy[g] && cdb_tag == TW'(g + 1) |=> !busy[g]);
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg_chk
    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid && rstat[r] != cdb_tag |=> $stable(regf[r]));
  end

endmodule

// File: tb/tb_resv_station.sv
`timescale 1ns/1ps
module tb_resv_station;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [3:0] iss_op = '0;
  logic [2:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic iss_ready;
  logic [TW-1:0] iss_tag;
  logic cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [15:0] cdb_data = '0;
  logic dsp_valid;
  logic dsp_ready = 1'b0;
  logic [3:0] dsp_op;
  logic [TW-1:0] dsp_tag;
  logic [15:0] dsp_opa, dsp_opb;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  resv_station dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
    .dsp_tag(dsp_tag), .dsp_opa(dsp_opa), .dsp_opb(dsp_opb)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] d, sa, sb,
                       input logic [TW-1:0] etag, input string req);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_src_a = sa; iss_src_b = sb;
    #1;
    chk(req, "iss_ready", iss_ready, 1);
    chk(req, "iss_tag", iss_tag, etag);
    @(posedge clk); #1;
    iss_valid = 1'b0;
  endtask

  task automatic issue_bc(input logic [3:0] op, input logic [2:0] d, sa, sb,
                          input logic [TW-1:0] etag, input logic [TW-1:0] bt,
                          input logic [15:0] bd, input string req);
    @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_src_a = sa; iss_src_b = sb;
    cdb_valid = 1'b1; cdb_tag = bt; cdb_data = bd;
    #1;
    chk(req, "iss_tag", iss_tag, etag);
    @(posedge clk); #1;
    iss_valid = 1'b0; cdb_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] t, input logic [15:0] d);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    @(posedge clk); #1;
    cdb_valid = 1'b0;
  endtask

  task automatic take(input logic [3:0] op, input logic [15:0] a, b,
                      input logic [TW-1:0] t, input string req);
    @(negedge clk);
    dsp_ready = 1'b1;
    #1;
    chk(req, "dsp_valid", dsp_valid, 1);
    chk(req, "dsp_tag", dsp_tag, t);
    chk(req, "dsp_op", dsp_op, op);
    chk(req, "dsp_opa", dsp_opa, a);
    chk(req, "dsp_opb", dsp_opb, b);
    @(posedge clk); #1;
    dsp_ready = 1'b0;
  endtask

  task automatic idle(input string req);
    @(negedge clk); #1;
    chk(req, "dsp_valid idle", dsp_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R10", "iss_ready", iss_ready, 1);
    chk("R10", "iss_tag", iss_tag, 1);
    chk("R10", "dsp_valid", dsp_valid, 0);
  endtask

  task automatic t_basic;
    issue(4'h1, 3'd1, 3'd2, 3'd3, 3'd1, "R1");
    take(4'h1, 16'h0000, 16'h0000, 3'd1, "R10");
    idle("R5");
    bcast(3'd1, 16'h1111);
    @(negedge clk); #1;
    chk("R9", "iss_tag after free", iss_tag, 1);
  endtask

  task automatic t_wait;
    issue(4'h2, 3'd2, 3'd0, 3'd0, 3'd1, "R1");
    issue(4'h3, 3'd3, 3'd2, 3'd1, 3'd2, "R3");
    take(4'h2, 16'h0000, 16'h0000, 3'd1, "R5");
    idle("R5");
    bcast(3'd1, 16'h2222);
    take(4'h3, 16'h2222, 16'h1111, 3'd2, "R2");
    bcast(3'd2, 16'h3333);
  endtask

  task automatic t_age;
    issue(4'h4, 3'd4, 3'd1, 3'd1, 3'd1, "R3");
    issue(4'h5, 3'd5, 3'd2, 3'd3, 3'd2, "R3");
    take(4'h4, 16'h1111, 16'h1111, 3'd1, "R7");
    bcast(3'd1, 16'h4444);
    issue(4'h6, 3'd6, 3'd4, 3'd0, 3'd1, "R9");
    take(4'h5, 16'h2222, 16'h3333, 3'd2, "R7");
    take(4'h6, 16'h4444, 16'h0000, 3'd1, "R7");
    bcast(3'd2, 16'h5555);
    bcast(3'd1, 16'h6666);
  endtask

  task automatic t_forward;
    issue(4'h7, 3'd7, 3'd0, 3'd0, 3'd1, "R1");
    take(4'h7, 16'h0000, 16'h0000, 3'd1, "R5");
    issue_bc(4'h8, 3'd0, 3'd7, 3'd5, 3'd2, 3'd1, 16'h7777, "R8");
    take(4'h8, 16'h7777, 16'h5555, 3'd2, "R8");
    bcast(3'd2, 16'h0ABC);
  endtask

  task automatic t_last_writer;
    issue(4'h9, 3'd6, 3'd0, 3'd0, 3'd1, "R3");
    issue(4'hA, 3'd6, 3'd0, 3'd0, 3'd2, "R1");
    take(4'h9, 16'h0ABC, 16'h0ABC, 3'd1, "R7");
    take(4'hA, 16'h0ABC, 16'h0ABC, 3'd2, "R7");
    bcast(3'd2, 16'hB0B0);
    bcast(3'd1, 16'hA0A0);
    issue(4'hB, 3'd1, 3'd6, 3'd6, 3'd1, "R6");
    take(4'hB, 16'hB0B0, 16'hB0B0, 3'd1, "R6");
    bcast(3'd1, 16'h1212);
  endtask

  task automatic t_full;
    issue(4'hC, 3'd2, 3'd1, 3'd1, 3'd1, "R1");
    issue(4'hD, 3'd3, 3'd2, 3'd1, 3'd2, "R1");
    issue(4'hE, 3'd4, 3'd3, 3'd0, 3'd3, "R1");
    issue(4'hF, 3'd5, 3'd0, 3'd0, 3'd4, "R1");
    @(negedge clk);
    iss_valid = 1'b1; iss_op = 4'h0; iss_dst = 3'd7; iss_src_a = 3'd0; iss_src_b = 3'd0;
    #1;
    chk("R4", "iss_ready when full", iss_ready, 0);
    @(posedge clk); #1;
    iss_valid = 1'b0;
    take(4'hC, 16'h1212, 16'h1212, 3'd1, "R7");
    take(4'hF, 16'h0ABC, 16'h0ABC, 3'd4, "R5");
    idle("R4");
    bcast(3'd1, 16'h2020);
    take(4'hD, 16'h2020, 16'h1212, 3'd2, "R2");
    bcast(3'd2, 16'h3030);
    take(4'hE, 16'h3030, 16'h0ABC, 3'd3, "R2");
    bcast(3'd3, 16'h4040);
    bcast(3'd4, 16'h5050);
    issue(4'h1, 3'd0, 3'd7, 3'd7, 3'd1, "R9");
    take(4'h1, 16'h7777, 16'h7777, 3'd1, "R4");
    bcast(3'd1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wait();
    t_age();
    t_forward();
    t_last_writer();
    t_full();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule